// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table held in memory. A requester presents a virtual address, a read/write flag and the frame number of the root (outer) table. The walker then reads one outer-table entry, which names the frame of an inner table. It then reads one inner-table entry, which names the data frame. The physical address is that frame joined with the 12-bit page offset.

Both entries are 32 bits wide. Bits [31:12] carry a frame number, bit 0 marks the entry valid, bit 1 marks a page writable, and bits [11:2] are ignored. An invalid entry at either level ends the walk with a fault, and so does a write to a page that is not writable. The fault code tells the three causes apart. Memory reads use a request/acknowledge handshake that may take any number of cycles. Each walk ends with a single response pulse, after which the walker takes the next request.

Top module: `page_walker`

## Requirements
- R1: After reset, req_ready is 1, mem_req is 0 and rsp_valid is 0.
- R2: The first read of a walk goes to address {root_frame, vaddr[31:22], 2'b00}, which is the root table base plus four times the outer index.
- R3: The second read goes to {outer_entry[31:12], vaddr[21:12], 2'b00}, which is the inner table base taken from the outer entry plus four times the inner index.
- R4: mem_req stays high and mem_addr stays unchanged until a cycle with mem_ack high. Read data is taken in that cycle, and any number of wait cycles is accepted.
- R5: On a successful walk, rsp_code is 0 and rsp_paddr is {inner_entry[31:12], vaddr[11:0]}.
- R6: If the outer entry has bit 0 clear, the walk ends after that single read with rsp_code 1 and rsp_paddr 0.
- R7: If the inner entry has bit 0 clear, rsp_code is 2 and rsp_paddr is 0.
- R8: A write through a valid inner entry with bit 1 clear ends with rsp_code 3 and rsp_paddr 0, while a read of the same page succeeds. Bit 1 of the outer entry is not consulted.
- R9: rsp_valid is high for exactly one cycle per walk, and req_ready is high again in the next cycle. While a walk is in progress, req_ready is 0 and req_valid is ignored.
- R10: An invalid inner entry reports code 2 even on a write to a page that is not writable, so validity takes precedence over write protection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle; request accepted when both are high |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| root_frame | input | 20 | Frame number of the outer table |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address (0 on a fault) |
| rsp_code | output | 2 | 0 ok, 1 outer invalid, 2 inner invalid, 3 write protected |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_ack | input | 1 | Memory read data valid this cycle |
| mem_rdata | input | 32 | Table entry read from memory |

## Verification
The hardest conditions to reach from the ports are a memory that stalls for many cycles in the middle of a walk and a request that arrives while the walker is busy. Either one can expose an address that changes during the stall or a walk that restarts partway through. The bench's memory model acknowledges after a latency that each scenario sets. While it waits, it compares the address it sees with the one it first sampled. One scenario holds req_valid high with a different address through a slow walk and confirms that the response still belongs to the first request. The table entries sit at the edges of both index fields, and the fault entries have their unused flag bits set, so that a wrong bit choice shows up in the result.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    // Geometry: page offset width sets everything else; a table fills one page.
    localparam int OFF_W   = 12;
    localparam int IDX_W   = OFF_W - 2;
    localparam int VA_W    = OFF_W + 2 * IDX_W;
    localparam int PTE_W   = VA_W;
    localparam int FRAME_W = VA_W - OFF_W;
    localparam int RSVD_W  = OFF_W - 2;

    typedef enum logic [1:0] {
        FLT_NONE       = 2'd0,
        FLT_OUTER_INV  = 2'd1,
        FLT_INNER_INV  = 2'd2,
        FLT_WRITE_PROT = 2'd3
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_OUTER,
        ST_WAIT_OUTER,
        ST_READ_INNER,
        ST_WAIT_INNER,
        ST_RESP
    } walk_st_e;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [RSVD_W-1:0]  rsvd;
        logic               wr;
        logic               vld;
    } pte_t;

    typedef struct packed {
        logic [IDX_W-1:0] outer;
        logic [IDX_W-1:0] inner;
        logic [OFF_W-1:0] off;
    } va_t;

    // Byte address of entry idx in a table that starts at frame base.
    function automatic logic [VA_W-1:0] slot_addr(input logic [FRAME_W-1:0] base,
                                                  input logic [IDX_W-1:0]   idx);
        return {base, idx, 2'b00};
    endfunction
endpackage

// File: rtl/ptw_entry_eval.sv
module ptw_entry_eval
    import ptw_pkg::*;
(
    input  pte_t   entry,
    input  logic   leaf,
    input  logic   is_write,
    output fault_e code
);
    // Validity first at either level (R10); permission only on the leaf (R8).
    always_comb begin
        code = FLT_NONE;
        if (!entry.vld) begin
            code = leaf ? FLT_INNER_INV : FLT_OUTER_INV;
        end else if (leaf && is_write && !entry.wr) begin
            code = FLT_WRITE_PROT;
        end
    end
endmodule

// File: rtl/ptw_mem_if.sv
module ptw_mem_if
    import ptw_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [VA_W-1:0] start_addr,
    input  logic            mem_ack,
    output logic            mem_req,
    output logic [VA_W-1:0] mem_addr,
    output logic            hit
);
    logic            req_q;
    logic [VA_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= 1'b0;
            addr_q <= '0;
        end else if (start) begin
            req_q  <= 1'b1;
            addr_q <= start_addr;
        end else if (req_q && mem_ack) begin
            req_q  <= 1'b0;
        end
    end

    assign mem_req  = req_q;
    assign mem_addr = addr_q;
    assign hit      = req_q && mem_ack;

    // R4: an outstanding read holds its request and address until acknowledged
    p_hold_addr_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R4: a new read is never issued over an outstanding one
    p_no_overlap_r4: assert property (@(posedge clk) disable iff (rst)
        start |-> !mem_req);
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  va_t                req_vaddr,
    input  logic               req_write,
    input  logic [FRAME_W-1:0] root_frame,
    output logic               req_ready,
    output logic               rsp_valid,
    output logic [VA_W-1:0]    rsp_paddr,
    output fault_e             rsp_code,
    output logic               issue,
    output logic [VA_W-1:0]    issue_addr,
    input  logic               hit,
    input  pte_t               rdata,
    output logic               eval_leaf,
    output logic               eval_write,
    input  fault_e             eval_code
);
    walk_st_e           st_q;
    va_t                va_q;
    logic               wr_q;
    logic [FRAME_W-1:0] base_q;
    fault_e             code_q;
    logic [VA_W-1:0]    paddr_q;
    logic               unused_attr;

    assign unused_attr = ^rdata.rsvd;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            va_q    <= '0;
            wr_q    <= 1'b0;
            base_q  <= '0;
            code_q  <= FLT_NONE;
            paddr_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (req_valid) begin
                    va_q   <= req_vaddr;
                    wr_q   <= req_write;
                    base_q <= root_frame;
                    st_q   <= ST_READ_OUTER;
                end
                ST_READ_OUTER: st_q <= ST_WAIT_OUTER;
                ST_WAIT_OUTER: if (hit) begin
                    if (eval_code != FLT_NONE) begin
                        code_q  <= eval_code;
                        paddr_q <= '0;
                        st_q    <= ST_RESP;
                    end else begin
                        base_q <= rdata.frame;
                        st_q   <= ST_READ_INNER;
                    end
                end
                ST_READ_INNER: st_q <= ST_WAIT_INNER;
                ST_WAIT_INNER: if (hit) begin
                    code_q  <= eval_code;
                    paddr_q <= (eval_code == FLT_NONE) ? {rdata.frame, va_q.off} : '0;
                    st_q    <= ST_RESP;
                end
                ST_RESP: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        issue      = (st_q == ST_READ_OUTER) || (st_q == ST_READ_INNER);
        issue_addr = slot_addr(base_q, (st_q == ST_READ_OUTER) ? va_q.outer : va_q.inner);
        eval_leaf  = (st_q == ST_WAIT_INNER);
        eval_write = wr_q;
        req_ready  = (st_q == ST_IDLE);
        rsp_valid  = (st_q == ST_RESP);
        rsp_paddr  = paddr_q;
        rsp_code   = code_q;
    end

    // R9: single-cycle response, idle right after
    p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R6: a faulting walk never hands out an address
    p_fault_no_addr_r6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code != FLT_NONE) |-> (rsp_paddr == '0));

    // R5: page offset passes through unchanged
    p_offset_keep_r5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code == FLT_NONE) |-> (rsp_paddr[OFF_W-1:0] == va_q.off));
endmodule

// File: rtl/page_walker.sv
module page_walker
    import ptw_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [VA_W-1:0]     req_vaddr,
    input  logic                req_write,
    input  logic [FRAME_W-1:0]  root_frame,
    output logic                rsp_valid,
    output logic [VA_W-1:0]     rsp_paddr,
    output logic [1:0]          rsp_code,
    output logic                mem_req,
    output logic [VA_W-1:0]     mem_addr,
    input  logic                mem_ack,
    input  logic [PTE_W-1:0]    mem_rdata
);
    logic            issue;
    logic [VA_W-1:0] issue_addr;
    logic            hit;
    logic            eval_leaf;
    logic            eval_write;
    fault_e          eval_code;
    fault_e          code_w;
    pte_t            entry_w;

    assign entry_w  = pte_t'(mem_rdata);
    assign rsp_code = code_w;

    ptw_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_vaddr  (va_t'(req_vaddr)),
        .req_write  (req_write),
        .root_frame (root_frame),
        .req_ready  (req_ready),
        .rsp_valid  (rsp_valid),
        .rsp_paddr  (rsp_paddr),
        .rsp_code   (code_w),
        .issue      (issue),
        .issue_addr (issue_addr),
        .hit        (hit),
        .rdata      (entry_w),
        .eval_leaf  (eval_leaf),
        .eval_write (eval_write),
        .eval_code  (eval_code)
    );

    ptw_mem_if u_mem (
        .clk        (clk),
        .rst        (rst),
        .start      (issue),
        .start_addr (issue_addr),
        .mem_ack    (mem_ack),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .hit        (hit)
    );

    ptw_entry_eval u_eval (
        .entry    (entry_w),
        .leaf     (eval_leaf),
        .is_write (eval_write),
        .code     (eval_code)
    );

    // R1/R9: an idle walker has no read in flight
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_req);
endmodule

// File: tb/sim_page_walker.sv
module sim_page_walker;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic [19:0] root_frame = 20'h00010;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_code;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int vectors = 0;
    int miscompares = 0;
    int lat = 0;
    int n_reads = 0;
    logic [31:0] addr_log [4];
    logic [31:0] mem [logic [31:0]];

    always #(CLK_PERIOD/2) clk = ~clk;

    page_walker u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write), .root_frame(root_frame),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_code(rsp_code),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // Memory model: ack after lat wait cycles, checking address stability (R4).
    initial begin
        int wait_cnt = 0;
        logic [31:0] seen = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack  = 1'b0;
                wait_cnt = 0;
            end else if (mem_req) begin
                if (wait_cnt == 0) seen = mem_addr;
                if (wait_cnt >= lat) begin
                    chk("R4 address held during stall", mem_addr, seen);
                    mem_ack   = 1'b1;
                    mem_rdata = mem_rd(mem_addr);
                    if (n_reads < 4) addr_log[n_reads] = mem_addr;
                    n_reads++;
                    wait_cnt = 0;
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    task automatic wait_rsp(input string tag);
        int t = 0;
        while (!rsp_valid && t < 500) begin
            @(negedge clk);
            t++;
        end
        chk({tag, " response arrives"}, {31'b0, rsp_valid}, 32'd1);
    endtask

    task automatic walk(input string tag, input logic [31:0] va, input logic wr, input int l,
                        input logic [1:0] ecode, input logic [31:0] epa, input int ereads,
                        input logic [31:0] ea0, input logic [31:0] ea1);
        lat = l;
        n_reads = 0;
        @(negedge clk);
        chk({tag, " R9 ready before request"}, {31'b0, req_ready}, 32'd1);
        req_valid = 1'b1;
        req_vaddr = va;
        req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R9 busy after accept"}, {31'b0, req_ready}, 32'd0);
        wait_rsp(tag);
        chk({tag, " code"}, {30'b0, rsp_code}, {30'b0, ecode});
        chk({tag, " paddr"}, rsp_paddr, epa);
        chk({tag, " read count"}, n_reads, ereads);
        chk({tag, " R2 outer entry address"}, addr_log[0], ea0);
        if (ereads == 2) chk({tag, " R3 inner entry address"}, addr_log[1], ea1);
        @(negedge clk);
        chk({tag, " R9 strobe ends"}, {31'b0, rsp_valid}, 32'd0);
        chk({tag, " R9 ready again"}, {31'b0, req_ready}, 32'd1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset ready", {31'b0, req_ready}, 32'd1);
        chk("R1 reset mem_req", {31'b0, mem_req}, 32'd0);
        chk("R1 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
        rst = 1'b0;
    endtask

    task automatic t_read_ok();
        walk("R5 read page A", 32'h00C05123, 1'b0, 0, 2'd0, 32'h12345123, 2, 32'h0001000C, 32'h00020014);
        walk("R5 read page A slow", 32'h00C05123, 1'b0, 7, 2'd0, 32'h12345123, 2, 32'h0001000C, 32'h00020014);
    endtask

    task automatic t_index_edges();
        walk("R3 edge indices", 32'h003FF000, 1'b0, 2, 2'd0, 32'hFFFFF000, 2, 32'h00010000, 32'h00040FFC);
    endtask

    task automatic t_write_ok();
        // Outer entry of page A has bit 1 clear; only the leaf matters (R8)
        walk("R8 write writable page", 32'h00C05123, 1'b1, 1, 2'd0, 32'h12345123, 2, 32'h0001000C, 32'h00020014);
    endtask

    task automatic t_write_prot();
        walk("R8 read read-only page", 32'h00C06FFF, 1'b0, 1, 2'd0, 32'h0ABCDFFF, 2, 32'h0001000C, 32'h00020018);
        walk("R8 write read-only page", 32'h00C06FFF, 1'b1, 3, 2'd3, 32'h0, 2, 32'h0001000C, 32'h00020018);
    endtask

    task automatic t_outer_invalid();
        walk("R6 outer invalid", 32'hFFC00010, 1'b0, 4, 2'd1, 32'h0, 1, 32'h00010FFC, 32'h0);
    endtask

    task automatic t_inner_invalid();
        walk("R7 inner invalid read", 32'h00C07000, 1'b0, 0, 2'd2, 32'h0, 2, 32'h0001000C, 32'h0002001C);
        walk("R10 inner invalid write", 32'h00C07000, 1'b1, 2, 2'd2, 32'h0, 2, 32'h0001000C, 32'h0002001C);
    endtask

    task automatic t_busy();
        lat = 5;
        n_reads = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = 32'h00C05123;
        req_write = 1'b0;
        @(negedge clk);
        req_vaddr = 32'h00C06FFF;
        req_write = 1'b1;
        wait_rsp("R9 busy");
        req_valid = 1'b0;
        chk("R9 request during walk ignored paddr", rsp_paddr, 32'h12345123);
        chk("R9 request during walk ignored code", {30'b0, rsp_code}, 32'd0);
        chk("R9 request during walk read count", n_reads, 2);
        @(negedge clk);
        chk("R9 idle after busy walk", {31'b0, req_ready}, 32'd1);
    endtask

    initial begin
        mem[32'h0001000C] = 32'h00020001;
        mem[32'h00020014] = 32'h12345003;
        mem[32'h00020018] = 32'h0ABCD001;
        mem[32'h0002001C] = 32'h55555000;
        mem[32'h00010FFC] = 32'h00030002;
        mem[32'h00010000] = 32'h00040001;
        mem[32'h00040FFC] = 32'hFFFFF001;
        t_reset();
        t_read_ok();
        t_index_edges();
        t_write_ok();
        t_write_prot();
        t_outer_invalid();
        t_inner_invalid();
        t_busy();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule